// File: doc/BRIEF.md
# Move-Only Register Transfer Core

This block is the smallest useful processor core: it executes a single instruction kind, a register-to-register move, across one shared 16-bit data bus. A program counter addresses an external instruction store. Each fetched 16-bit word is decoded into a source number and a destination number. On the following clock edge the chosen source drives the bus and the chosen destination captures it. Decoding and execution overlap, so one move completes on every clock while the next one is being decoded.

Fifteen numbered registers hang on the bus: five general registers, an LED output register, a switch sampling register, a seven-segment output register, two source-operand registers, a destination-operand register, a RAM data register, a memory data register, the program counter and the instruction register. Number 0 names no register. As a source it puts zero on the bus, and as a destination nothing is written. The switch register follows the switch pins on every clock. The switch, destination-operand and instruction registers can not be written from the bus. Words whose top nibble is not zero are not moves and cause no transfer, so a program is a list of move words that starts with the all-zero word.

Top module: `mov_core`

## Requirements
- R1: `pc_addr` shows the program counter. The counter is 16 bits wide and rises by one on every clock edge that does not load it, wrapping from 0xFFFF to 0x0000.
- R2: A word is a move when bits 15:12 are 0000. Bits 7:4 give the source number, bits 3:0 give the destination number, and bits 11:8 are ignored. The transfer for the word presented on `instr` while `pc_addr` = k happens on the second clock edge after `pc_addr` first shows k.
- R3: The register numbers are: 1 to 5 general, 6 LED, 7 switch, 8 seven-segment, 9 and 10 source operands, 11 destination operand, 12 RAM data, 13 memory data, 14 program counter, 15 instruction register. A move copies the source value into the destination, and `led` and `seg` always show registers 6 and 8.
- R4: Source number 0 drives 0x0000 on the bus, so the destination is cleared. Destination number 0 changes no register.
- R5: A move whose destination is 7, 11 or 15 changes no register.
- R6: The switch register takes the value of `sw` on every clock edge, whatever instruction is running.
- R7: A word whose bits 15:12 are not 0000 causes no transfer one cycle later.
- R8: The source and destination numbers are turned into one-hot drive and load lines: at most one line of each set is active, and line n only for number n.
- R9: A move to number 14 loads the bus value into the program counter in place of the increment. As a source, number 14 gives the address of the moving word plus one, and number 15 gives the moving word itself.
- R10: While `rst` is high at a clock edge, the counter, the decoded selects and every register return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw | input | 16 | Switch pins, sampled every clock |
| instr | input | 16 | Instruction word read at `pc_addr` |
| pc_addr | output | 16 | Program counter, instruction address |
| led | output | 16 | LED register (number 6) |
| seg | output | 16 | Seven-segment register (number 8) |

## Verification
The assertions assume that `instr` is a function of `pc_addr` alone, settled before each edge, that `sw` changes only away from the rising edge, and that reset is held for a few cycles at the start. The bench drives `instr` from a small program table indexed by the low bits of `pc_addr` and changes `sw` only on falling edges. It edits the table only on falling edges. In one phase the program jumps back to its start through the counter. In the other phase that jump is replaced by a no-op so the counter runs through its wrap.

// File: rtl/mov_core_pkg.sv
package mov_core_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 16;
  localparam int SEL_W  = 4;
  localparam int OPC_W  = 4;
  localparam int NREG   = 1 << SEL_W;

  // register numbers whose position the decode depends on
  localparam int IDX_NONE  = 0;
  localparam int IDX_LED   = 6;
  localparam int IDX_SW    = 7;
  localparam int IDX_SEG   = 8;
  localparam int IDX_DSTOP = 11;
  localparam int IDX_PC    = 14;
  localparam int IDX_IR    = 15;

  localparam logic [OPC_W-1:0] OPC_MOVE = '0;

  function automatic logic bus_writable(input int idx);
    return !(idx == IDX_NONE || idx == IDX_SW || idx == IDX_DSTOP ||
             idx == IDX_IR || idx == IDX_PC);
  endfunction
endpackage

// File: rtl/mov_onehot_dec.sv
module mov_onehot_dec #(
  parameter int SEL_W = 4,
  localparam int LINES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  output logic [LINES-1:0] lines
);
  // line 0 stays inactive: number 0 selects nothing
  for (genvar n = 0; n < LINES; n++) begin : g_line
    if (n == 0) begin : g_none
      assign lines[n] = 1'b0;
    end else begin : g_sel
      assign lines[n] = (sel == SEL_W'(n));
    end
  end
endmodule

// File: rtl/mov_ctrl.sv
module mov_ctrl
  import mov_core_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int SW_ = SEL_W,
  parameter int OW = OPC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] instr,
  input  logic          pc_load,
  input  logic [AW-1:0] pc_wdata,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic [SW_-1:0] src_sel,
  output logic [SW_-1:0] dst_sel
);
  localparam int OPC_LSB = DW - OW;

  logic is_move;
  assign is_move = (instr[DW-1:OPC_LSB] == OW'(OPC_MOVE));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      ir      <= '0;
      src_sel <= '0;
      dst_sel <= '0;
    end else begin
      pc <= pc_load ? pc_wdata : pc + 1'b1;
      ir <= instr;
      if (is_move) begin
        src_sel <= instr[2*SW_-1:SW_];
        dst_sel <= instr[SW_-1:0];
      end else begin
        src_sel <= '0;
        dst_sel <= '0;
      end
    end
  end

  // R1: counter advances by one when not loaded
  a_r1_pc_step: assert property (@(posedge clk) disable iff (rst)
    !pc_load |=> (pc == $past(pc) + 1'b1));
  // R9: a load takes the bus value
  a_r9_pc_load: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> (pc == $past(pc_wdata)));
  // R2: fields of a move word become the selects
  a_r2_fields: assert property (@(posedge clk) disable iff (rst)
    (instr[DW-1:OPC_LSB] == '0) |=>
      (src_sel == $past(instr[7:4]) && dst_sel == $past(instr[3:0])));
  // R7: other opcodes leave both selects idle
  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    (instr[DW-1:OPC_LSB] != '0) |=> (src_sel == '0 && dst_sel == '0));
endmodule

// File: rtl/mov_datapath.sv
module mov_datapath
  import mov_core_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NR = NREG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NR-1:0] drv_en,
  input  logic [NR-1:0] ld_en,
  input  logic [DW-1:0] sw,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] ir,
  output logic [DW-1:0] bus,
  output logic          pc_load,
  output logic [DW-1:0] led,
  output logic [DW-1:0] seg
);
  logic [NR-1:0][DW-1:0] src_val;

  for (genvar i = 0; i < NR; i++) begin : g_reg
    if (i == IDX_NONE) begin : g_zero
      assign src_val[i] = '0;
    end else if (i == IDX_PC) begin : g_pc
      assign src_val[i] = DW'(pc);
    end else if (i == IDX_IR) begin : g_ir
      assign src_val[i] = ir;
    end else if (i == IDX_SW) begin : g_sw
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= sw;
      end
      assign src_val[i] = q;
    end else if (!bus_writable(i)) begin : g_ro
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
      end
      assign src_val[i] = q;
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (ld_en[i]) q <= bus;
      end
      assign src_val[i] = q;
    end
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NR; i++) begin
      bus |= {DW{drv_en[i]}} & src_val[i];
    end
  end

  assign pc_load = ld_en[IDX_PC];
  assign led     = src_val[IDX_LED];
  assign seg     = src_val[IDX_SEG];

  // R8: at most one driver and one loader
  a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv_en) && $onehot0(ld_en));
  // R6: switch register follows the pins
  a_r6_sw_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (src_val[IDX_SW] == $past(sw)));
  // R4: no driver means a cleared destination
  a_r4_zero_src: assert property (@(posedge clk) disable iff (rst)
    (ld_en[1] && drv_en == '0) |=> (src_val[1] == '0));
  // R5: destination operand register never changes after reset
  a_r5_ro_dstop: assert property (@(posedge clk) disable iff (rst)
    ld_en[IDX_DSTOP] |=> $stable(src_val[IDX_DSTOP]));
  // R3: a loaded register holds the bus value
  a_r3_copy: assert property (@(posedge clk) disable iff (rst)
    ld_en[IDX_LED] |=> (led == $past(bus)));
endmodule

// File: rtl/mov_core.sv
module mov_core
  import mov_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sw,
  input  logic [DATA_W-1:0] instr,
  output logic [ADDR_W-1:0] pc_addr,
  output logic [DATA_W-1:0] led,
  output logic [DATA_W-1:0] seg
);
  logic [SEL_W-1:0]  src_sel, dst_sel;
  logic [NREG-1:0]   drv_en, ld_en;
  logic [DATA_W-1:0] ir, bus;
  logic              pc_load;

  mov_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .instr    (instr),
    .pc_load  (pc_load),
    .pc_wdata (bus[ADDR_W-1:0]),
    .pc       (pc_addr),
    .ir       (ir),
    .src_sel  (src_sel),
    .dst_sel  (dst_sel)
  );

  mov_onehot_dec #(.SEL_W(SEL_W)) u_src_dec (.sel(src_sel), .lines(drv_en));
  mov_onehot_dec #(.SEL_W(SEL_W)) u_dst_dec (.sel(dst_sel), .lines(ld_en));

  mov_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .drv_en  (drv_en),
    .ld_en   (ld_en),
    .sw      (sw),
    .pc      (pc_addr),
    .ir      (ir),
    .bus     (bus),
    .pc_load (pc_load),
    .led     (led),
    .seg     (seg)
  );
endmodule

// File: tb/mov_core_tb.sv
module mov_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sw  = 16'h0000;
  logic [15:0] instr;
  logic [15:0] pc_addr, led, seg;
  logic [15:0] rom [64];

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign instr = rom[pc_addr[5:0]];

  mov_core u_dut (
    .clk(clk), .rst(rst), .sw(sw), .instr(instr),
    .pc_addr(pc_addr), .led(led), .seg(seg)
  );

  // behavioural reference
  logic [15:0] m_pc, m_ir, m_src, m_dst;
  logic [15:0] m_r [16];
  bit          m_nm;
  string       m_tag = "R10";
  bit          wrap_seen = 0;

  function automatic logic [15:0] m_val(input int n);
    if (n == 0)  return 16'h0000;
    if (n == 14) return m_pc;
    if (n == 15) return m_ir;
    return m_r[n];
  endfunction

  always @(posedge clk) begin
    logic [15:0] b, w, nxt;
    cycles++;
    if (rst) begin
      m_pc = 0; m_ir = 0; m_src = 0; m_dst = 0; m_nm = 0;
      for (int i = 0; i < 16; i++) m_r[i] = 0;
      m_tag = "R10";
    end else begin
      b = m_val(int'(m_src));
      if (m_nm)                                    m_tag = "R7";
      else if (m_dst == 14)                        m_tag = "R9";
      else if (m_dst == 7 || m_dst == 11 || m_dst == 15) m_tag = "R5";
      else if (m_src == 0 || m_dst == 0)           m_tag = "R4";
      else if (m_src == 7)                         m_tag = "R6";
      else if (m_src == 14 || m_src == 15)         m_tag = "R9";
      else                                         m_tag = "R3";
      if (!(m_dst inside {0, 7, 11, 14, 15})) m_r[m_dst] = b;
      m_r[7] = sw;
      nxt = (m_dst == 14) ? b : m_pc + 16'd1;
      w = rom[m_pc[5:0]];
      m_ir = w;
      if (w[15:12] == 4'h0) begin
        m_src = {12'h0, w[7:4]}; m_dst = {12'h0, w[3:0]}; m_nm = 0;
      end else begin
        m_src = 0; m_dst = 0; m_nm = 1;
      end
      if (m_pc == 16'hFFFF && nxt == 16'h0000) wrap_seen = 1;
      m_pc = nxt;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d",
               req, what, act, exp, cycles);
    end
  endtask

  // compare on every falling edge once out of reset
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R1", "pc_addr", pc_addr, m_pc);
      check(m_tag, "led", led, m_r[6]);
      check(m_tag, "seg", seg, m_r[8]);
    end
  end

  // switch stimulus, changed away from the rising edge
  always @(negedge clk) begin
    if (!rst) sw <= {sw[14:0], sw[15] ^ sw[13] ^ sw[12] ^ sw[10]} ^ 16'h0001;
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) rom[i] = 16'h0000;
    rom[0]  = 16'h0000; // no-op first
    rom[1]  = 16'h0071; // switch -> R1 (R6)
    rom[2]  = 16'h0013; // R1 -> R3
    rom[3]  = 16'h0036; // R3 -> LED (R3)
    rom[4]  = 16'h0038; // R3 -> SEG
    rom[5]  = 16'h0003; // zero -> R3 (R4)
    rom[6]  = 16'h0036; // R3 -> LED shows zero
    rom[7]  = 16'h0017; // R1 -> switch: no effect (R5)
    rom[8]  = 16'h0076; // switch -> LED
    rom[9]  = 16'h0A1F; // R1 -> IR, unused field set: no effect (R5, R2)
    rom[10] = 16'h00F8; // IR -> SEG gives own word (R9)
    rom[11] = 16'h1016; // not a move (R7)
    rom[12] = 16'h001B; // R1 -> destination operand: no effect (R5)
    rom[13] = 16'h00B6; // dest operand -> LED shows zero
    rom[14] = 16'hF016; // not a move (R7)
    rom[15] = 16'h0012; // chain through all writable registers
    rom[16] = 16'h0024;
    rom[17] = 16'h0045;
    rom[18] = 16'h0059;
    rom[19] = 16'h009A;
    rom[20] = 16'h00AC;
    rom[21] = 16'h00CD;
    rom[22] = 16'h00D6; // R13 -> LED (R3)
    rom[23] = 16'h00E8; // PC -> SEG (R9)
    rom[24] = 16'h0010; // R1 -> none (R4)
    rom[25] = 16'h0060; // LED -> none
    rom[26] = 16'h0006; // zero -> LED
    rom[27] = 16'h0016;
    rom[40] = 16'h000E; // zero -> PC: jump to start (R9)

    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R10", "pc_addr after reset", pc_addr, 16'h0000);
    check("R10", "led after reset", led, 16'h0000);
    check("R10", "seg after reset", seg, 16'h0000);
    sw = 16'hA5C3;

    repeat (300) @(negedge clk);
    check("R9", "jump keeps pc low", {15'h0, pc_addr > 16'd64}, 16'h0000);
    rom[40] = 16'h0000; // let the counter run through its wrap
    repeat (66000) @(negedge clk);
    check("R1", "counter wrap observed", {15'h0, wrap_seen}, 16'h0001);

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10", "pc_addr after mid-run reset", pc_addr, 16'h0000);
    check("R10", "led after mid-run reset", led, 16'h0000);
    check("R10", "seg after mid-run reset", seg, 16'h0000);
    finish_run();
  end

  initial begin
    while (cycles < 150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    finish_run();
  end
endmodule